// File: doc/BRIEF.md
# UART Register Block with Receive Queue

This block is the processor-side face of a simple serial port. A bus master reaches four 32-bit word registers through a plain request/write-enable port. Bits [3:2] of the byte address pick the register. The four registers hold received data, data to transmit, a read-only status word and a control word.

Bytes from the serial receiver arrive on a byte-valid input. They are stored in an eight-entry first-in first-out queue, and each read of the receive-data register takes the oldest one out. A write to the transmit-data register sends the low byte to the serial transmitter as a one-cycle strobe.

A sticky pending flag drives a level interrupt whenever the control word enables it. The flag is set while received data waits and whenever a byte is sent. Parity and framing error flags come from the receiver logic and are reflected live in the status word.

Top module: `uart_regif`

## Requirements
- R1: Register index is byte address bits [3:2]: 0 receive data, 1 transmit data, 2 status, 3 control. Read data is combinational in the request cycle, and state changes at the following clock edge. Reading control returns the last value written to it. Reading transmit data returns the last value written to it.
- R2: Status word layout:
  - bit0: queue non-empty.
  - bit1: queue holds 8 bytes.
  - bit2: transmit empty, constant 1.
  - bit3: transmit full, constant 0.
  - bit4: pending flag.
  - bit5: overrun flag.
  - bit6: `frame_err_i`, passed through live.
  - bit7: `parity_err_i`, passed through live.
  - bits 31:8: zero.
- R3: `irq_o` is high exactly when the pending flag is set and control bit4 (interrupt enable) is 1.
- R4: Each cycle with `rx_valid_i` high and fewer than 8 bytes queued stores `rx_byte_i`. Bytes leave the queue in arrival order.
- R5: A byte arriving while 8 bytes are queued is discarded, even if a pop happens in the same cycle. The discard sets the overrun flag (status bit5).
- R6: A read of the receive-data register with bytes queued returns the oldest byte and removes it. On an empty queue the read returns the byte stored in the slot the next arrival would use, and the count stays at zero.
- R7: A control write with bit1 set empties the queue (write slot back to 0) and clears the overrun flag. Control bit0 is stored but has no other effect.
- R8: Writes to the status register and to the receive-data register change no state.
- R9: A transmit-data write raises `tx_strobe_o` for exactly the one cycle after the write edge. During that cycle `tx_byte_o` carries bits [7:0] of the written value.
- R10: The pending flag is set at any edge where the queue ends non-empty or a transmit write occurs. A status read clears it only when neither of those holds, and a status read returns the flag's value from before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the request cycle |
| rx_valid_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |
| frame_err_i | input | 1 | Framing error from receiver |
| parity_err_i | input | 1 | Parity error from receiver |
| tx_strobe_o | output | 1 | Transmit byte strobe |
| tx_byte_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The queue count has no direct port. An error in it first shows in the status bits [1:0] on the next status read, and in the byte order of the following data reads. A skipped or doubled pointer step gives a wrong byte on the first affected pop, so the order test catches it at most eight reads after the error. A pending flag that fails to clear, or clears too early, is visible on `irq_o` in the cycle after the status read. The overrun flag and the stale value returned by an empty read expose the full and empty boundaries in one access each.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int ST_RXVALID = 0;
  localparam int ST_RXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_TXFULL  = 3;
  localparam int ST_PEND    = 4;
  localparam int ST_OVERRUN = 5;
  localparam int ST_FRAME   = 6;
  localparam int ST_PARITY  = 7;

  localparam int CT_TXRST = 0;
  localparam int CT_RXRST = 1;
  localparam int CT_IE    = 4;
endpackage

// File: rtl/uart_regif_rxq.sv
module uart_regif_rxq #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  count_nx_o,
  output logic              full_o,
  output logic              drop_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr;
  logic [CNT_W-1:0]  count_q;
  logic              push_ok, pop_ok;

  assign full_o    = (count_q == CNT_W'(DEPTH));
  assign push_ok   = push_i && !full_o && !flush_i;
  assign pop_ok    = pop_i && (count_q != '0) && !flush_i;
  assign drop_o    = push_i && full_o && !flush_i;
  // oldest entry; when empty this lands on the next write slot (stale data)
  assign rd_ptr    = wr_ptr_q - count_q[PTR_W-1:0];
  assign rd_data_o = mem_q[rd_ptr];
  assign count_o   = count_q;

  always_comb begin
    if (flush_i) count_nx_o = '0;
    else         count_nx_o = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      count_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      count_q <= count_nx_o;
      if (flush_i) begin
        wr_ptr_q <= '0;
      end else if (push_ok) begin
        mem_q[wr_ptr_q] <= data_i;
        wr_ptr_q        <= wr_ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_regif_flags.sv
module uart_regif_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nonempty_nx_i,
  input  logic tx_set_i,
  input  logic stat_rd_i,
  input  logic irq_en_i,
  input  logic ovr_set_i,
  input  logic ovr_clr_i,
  output logic pend_o,
  output logic ovr_o,
  output logic irq_o
);
  logic pend_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      // set sources win over the read-clear
      pend_q <= (pend_q && !stat_rd_i) || tx_set_i || nonempty_nx_i;
      if (ovr_clr_i)      ovr_q <= 1'b0;
      else if (ovr_set_i) ovr_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;
  assign irq_o  = pend_q && irq_en_i;
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int RX_DEPTH = 8,
  parameter int BYTE_W   = 8,
  localparam int CNT_W   = $clog2(RX_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              frame_err_i,
  input  logic              parity_err_i,
  output logic              tx_strobe_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              rd_en, wr_en;
  logic              rxd_rd, txd_wr, stat_rd, ctrl_wr, rx_flush;
  logic [DATA_W-1:0] ctrl_q, txd_q;
  logic              tx_strobe_q;
  logic [BYTE_W-1:0] tx_byte_q;
  logic [BYTE_W-1:0] rxq_data;
  logic [CNT_W-1:0]  rxq_count, rxq_count_nx;
  logic              rxq_full, rxq_drop;
  logic              pend, ovr;
  logic [DATA_W-1:0] status;

  assign sel      = reg_sel_e'(bus_addr_i[3:2]);
  assign rd_en    = bus_req_i && !bus_we_i;
  assign wr_en    = bus_req_i && bus_we_i;
  assign rxd_rd   = rd_en && (sel == REG_RXD);
  assign stat_rd  = rd_en && (sel == REG_STAT);
  assign txd_wr   = wr_en && (sel == REG_TXD);
  assign ctrl_wr  = wr_en && (sel == REG_CTRL);
  assign rx_flush = ctrl_wr && bus_wdata_i[CT_RXRST];

  uart_regif_rxq #(.DEPTH(RX_DEPTH), .BYTE_W(BYTE_W)) u_rxq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rx_valid_i),
    .data_i     (rx_byte_i),
    .pop_i      (rxd_rd),
    .flush_i    (rx_flush),
    .rd_data_o  (rxq_data),
    .count_o    (rxq_count),
    .count_nx_o (rxq_count_nx),
    .full_o     (rxq_full),
    .drop_o     (rxq_drop)
  );

  uart_regif_flags u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .nonempty_nx_i (rxq_count_nx != '0),
    .tx_set_i      (txd_wr),
    .stat_rd_i     (stat_rd),
    .irq_en_i      (ctrl_q[CT_IE]),
    .ovr_set_i     (rxq_drop),
    .ovr_clr_i     (rx_flush),
    .pend_o        (pend),
    .ovr_o         (ovr),
    .irq_o         (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      txd_q       <= '0;
      tx_strobe_q <= 1'b0;
      tx_byte_q   <= '0;
    end else begin
      tx_strobe_q <= txd_wr;
      if (ctrl_wr) ctrl_q <= bus_wdata_i;
      if (txd_wr) begin
        txd_q     <= bus_wdata_i;
        tx_byte_q <= bus_wdata_i[BYTE_W-1:0];
      end
    end
  end

  always_comb begin
    status              = '0;
    status[ST_RXVALID]  = (rxq_count != '0);
    status[ST_RXFULL]   = rxq_full;
    status[ST_TXEMPTY]  = 1'b1;
    status[ST_TXFULL]   = 1'b0;
    status[ST_PEND]     = pend;
    status[ST_OVERRUN]  = ovr;
    status[ST_FRAME]    = frame_err_i;
    status[ST_PARITY]   = parity_err_i;
  end

  always_comb begin
    unique case (sel)
      REG_RXD:  bus_rdata_o = DATA_W'(rxq_data);
      REG_TXD:  bus_rdata_o = txd_q;
      REG_STAT: bus_rdata_o = status;
      default:  bus_rdata_o = ctrl_q;
    endcase
  end

  assign tx_strobe_o = tx_strobe_q;
  assign tx_byte_o   = tx_byte_q;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        sel_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rx_valid_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              pend_i,
  input logic              ie_i,
  input logic              irq_i,
  input logic              tx_strobe_i,
  input logic [7:0]        tx_byte_i
);
  logic txw, rxr, flush;
  assign txw   = req_i && we_i && (sel_i == 2'd1);
  assign rxr   = req_i && !we_i && (sel_i == 2'd0);
  assign flush = req_i && we_i && (sel_i == 2'd3) && wdata_i[1];

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  a_r5_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CNT_W'(DEPTH) && rx_valid_i && !rxr && !flush) |=> count_i == CNT_W'(DEPTH));

  a_r6_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxr && count_i != '0 && !rx_valid_i) |=> count_i == $past(count_i) - 1'b1);

  a_r7_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> count_i == '0);

  a_r3_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (ie_i && pend_i));

  a_r10_pend_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != '0) |-> pend_i);

  a_r9_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txw |=> (tx_strobe_i && tx_byte_i == $past(wdata_i[7:0])));

  a_r9_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txw |=> !tx_strobe_i);
endmodule

bind uart_regif uart_regif_chk #(.DEPTH(RX_DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (bus_req_i),
  .we_i        (bus_we_i),
  .sel_i       (bus_addr_i[3:2]),
  .wdata_i     (bus_wdata_i),
  .rx_valid_i  (rx_valid_i),
  .count_i     (rxq_count),
  .pend_i      (pend),
  .ie_i        (ctrl_q[4]),
  .irq_i       (irq_o),
  .tx_strobe_i (tx_strobe_o),
  .tx_byte_i   (tx_byte_o)
);

// File: tb/sim_uart_regif.sv
module sim_uart_regif;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam logic [1:0] OP_PUSH = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  // {req no[3:0], op[1:0], reg idx[1:0], data[31:0], expected[31:0]}
  localparam logic [71:0] VEC [NVEC] = '{
    {4'd2,  OP_RD,   2'd2, 32'h0,     32'h04},   // R2 reset status
    {4'd4,  OP_PUSH, 2'd0, 32'h11,    32'h0},    // R4
    {4'd4,  OP_PUSH, 2'd0, 32'h22,    32'h0},    // R4
    {4'd10, OP_RD,   2'd2, 32'h0,     32'h15},   // R10 pend from data
    {4'd6,  OP_RD,   2'd0, 32'h0,     32'h11},   // R6 oldest first
    {4'd4,  OP_RD,   2'd0, 32'h0,     32'h22},   // R4 order
    {4'd10, OP_RD,   2'd2, 32'h0,     32'h14},   // R10 sticky
    {4'd10, OP_RD,   2'd2, 32'h0,     32'h04},   // R10 cleared
    {4'd1,  OP_WR,   2'd3, 32'h10,    32'h0},    // R1
    {4'd1,  OP_RD,   2'd3, 32'h0,     32'h10},   // R1 ctrl readback
    {4'd9,  OP_WR,   2'd1, 32'h1A5,   32'h0},    // R9
    {4'd10, OP_RD,   2'd2, 32'h0,     32'h14},   // R10 pend from tx
    {4'd10, OP_RD,   2'd2, 32'h0,     32'h04},   // R10
    {4'd1,  OP_RD,   2'd1, 32'h0,     32'h1A5},  // R1 tx readback
    {4'd8,  OP_WR,   2'd2, 32'hFF,    32'h0},    // R8
    {4'd8,  OP_RD,   2'd2, 32'h0,     32'h04}    // R8 status unchanged
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rx_valid = 1'b0, frame_err = 1'b0, parity_err = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_strobe, irq;
  logic [7:0]  tx_byte;
  int          tests = 0, fails = 0;
  logic [31:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .frame_err_i(frame_err),
    .parity_err_i(parity_err), .tx_strobe_o(tx_strobe), .tx_byte_o(tx_byte),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [1:0] idx, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    req = 1'b1; we = w; addr = {idx, 2'b00}; wdata = d;
    #1 q = rdata;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R3 reset irq", {31'b0, irq}, 32'h0);
    chk("R9 reset strobe", {31'b0, tx_strobe}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [71:0] v;
      v = VEC[i];
      case (v[67:66])
        OP_PUSH: push(v[39:32]);
        OP_WR:   bus(1'b1, v[65:64], v[63:32], r);
        default: begin
          bus(1'b0, v[65:64], 32'h0, r);
          chk($sformatf("R%0d vec%0d", v[71:68], i), r, v[31:0]);
        end
      endcase
    end

    // R9: strobe only in the cycle after the write
    bus(1'b1, 2'd1, 32'h3C7, r);
    chk("R9 strobe high", {23'b0, tx_strobe, tx_byte}, {23'b0, 1'b1, 8'hC7});
    chk("R3 irq after tx", {31'b0, irq}, 32'h1);
    @(posedge clk); #1;
    chk("R9 strobe single", {31'b0, tx_strobe}, 32'h0);
    bus(1'b0, 2'd2, 32'h0, r);
    #1 chk("R3 irq cleared", {31'b0, irq}, 32'h0);

    // R7 flush then fill beyond capacity
    bus(1'b1, 2'd3, 32'h12, r);
    for (int k = 0; k < 9; k++) push(8'h40 + 8'(k));
    chk("R3 irq with data", {31'b0, irq}, 32'h1);
    bus(1'b0, 2'd2, 32'h0, r);
    chk("R5 full+overrun status", r, 32'h37);
    for (int k = 0; k < 8; k++) begin
      bus(1'b0, 2'd0, 32'h0, r);
      chk($sformatf("R4 pop %0d", k), r, 32'h40 + k);
    end
    bus(1'b0, 2'd2, 32'h0, r);
    chk("R5 overrun kept after drain", r, 32'h34);
    bus(1'b0, 2'd0, 32'h0, r);
    chk("R6 empty read stale", r, 32'h40);
    bus(1'b0, 2'd2, 32'h0, r);
    chk("R6 count stays zero", r, 32'h24);
    bus(1'b1, 2'd3, 32'h12, r);
    bus(1'b0, 2'd2, 32'h0, r);
    chk("R7 overrun cleared", r, 32'h04);

    // R7 flush drops queued data
    push(8'h71); push(8'h72);
    bus(1'b1, 2'd3, 32'h12, r);
    bus(1'b0, 2'd2, 32'h0, r);
    chk("R7 flush empties", r, 32'h14);
    push(8'h73);
    bus(1'b0, 2'd0, 32'h0, r);
    chk("R7 write slot reset", r, 32'h73);

    // R8 write to RX data register ignored
    push(8'h5A);
    bus(1'b1, 2'd0, 32'h99, r);
    bus(1'b0, 2'd0, 32'h0, r);
    chk("R8 rxd write ignored", r, 32'h5A);

    // R7 TX reset bit stored only, R3 enable gating
    bus(1'b1, 2'd3, 32'h01, r);
    bus(1'b0, 2'd3, 32'h0, r);
    chk("R7 ctrl bit0 stored", r, 32'h01);
    bus(1'b1, 2'd1, 32'h55, r);
    chk("R3 irq masked", {31'b0, irq}, 32'h0);
    bus(1'b0, 2'd2, 32'h0, r);
    chk("R10 pend while masked", r, 32'h14);

    // R2 live error inputs
    frame_err = 1'b1; parity_err = 1'b1;
    bus(1'b0, 2'd2, 32'h0, r);
    chk("R2 error bits", r, 32'hC4);
    frame_err = 1'b0;
    bus(1'b0, 2'd2, 32'h0, r);
    chk("R2 parity only", r, 32'h84);
    parity_err = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule